// File: doc/BRIEF.md
# Day and Seconds Real-Time Clock with Alarm

This block keeps wall time as two binary counts: a seconds-of-day value that runs from 0 to 86399, and a 15-bit day number. Both advance on a one-second strobe supplied from outside. A second pair of registers holds an alarm time in the same layout. Two interrupt sources feed one interrupt line. The alarm source fires when the running time reaches the alarm time. The update source fires on every strobe.

Software reaches the block over a synchronous register bus. The bus has single-cycle write and read strobes, a 3-bit word address and 16-bit data, and read data comes back registered. The seconds value is wider than one data word, so it is split into a low byte and a 9-bit high part. To set the time without a carry racing the writes, software can use this sequence. First it clears the low byte, which holds the high part still for 255 strobes. Then it writes the day, then the high part, and finally the low byte. The last write sets the exact time.

Top module: `rtc_daysec`

## Requirements
- R1: On a strobe, with no time register written in that cycle and the seconds value below 86399, the seconds value goes up by one and the day is unchanged.
- R2: On a strobe, with no time register written and the seconds value at or above 86399, the seconds value becomes 0 and the day goes up by one, wrapping from 32767 to 0.
- R3: Register addresses are: 0 day (bits 14:0), 1 seconds low byte (bits 7:0), 2 seconds high part (bits 8:0, seconds bits 16:8). Register bits outside these fields read as zero and ignore writes.
- R4: Addresses 3, 4 and 5 hold the alarm day, alarm low byte and alarm high part. They use the same field widths as addresses 0, 1 and 2.
- R5: When the day and seconds values become equal to the alarm values, status bit 0 is set once for that arrival.
- R6: Every strobe sets status bit 1.
- R7: After the low byte is written with 0, the next 255 strobes leave the high part unchanged, and the 256th strobe increments it.
- R8: A write to a time register takes effect at the next clock edge. If a strobe arrives in the same cycle, the write wins and the strobe is not applied to the counters.
- R9: Address 6 holds enable bits: bit 0 for the alarm source, bit 1 for the update source, where 1 means unmasked. Address 7 holds the status bits. Writing 1 to a status bit clears it, but a set in the same cycle wins. The interrupt output, one cycle after the status or enable bits change, equals the OR of the status bits that are enabled.
- R10: Reset clears both counters, all alarm fields, the enable bits, the status bits and the interrupt output.
- R11: Read data is captured at the clock edge of the cycle in which the read strobe is high, and it holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The assertions check the counting rules on every cycle: the increment, the wrap at the end of the day, a write winning over a strobe, the update status being set by each strobe, the interrupt output tracking the enabled status one cycle later, the reset values, and read data holding between reads. The arrival of the alarm, the 255-strobe carry window after a zero low byte, the masking of unused register bits and the day wrap at 32767 can only be shown by the bench's directed scenarios. The same holds for agreement with a reference model across random mixes of writes, strobes and reads.

// File: rtl/rtc_daysec_pkg.sv
package rtc_daysec_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_DAY      = 3'd0,
    A_SEC_LO   = 3'd1,
    A_SEC_HI   = 3'd2,
    A_ALM_DAY  = 3'd3,
    A_ALM_LO   = 3'd4,
    A_ALM_HI   = 3'd5,
    A_IRQ_EN   = 3'd6,
    A_IRQ_STAT = 3'd7
  } reg_addr_e;

  localparam int IRQ_ALARM = 0;
  localparam int IRQ_TICK  = 1;
  localparam int IRQ_N     = 2;
endpackage

// File: rtl/rtc_daysec_counter.sv
module rtc_daysec_counter #(
  parameter int DAY_W        = 15,
  parameter int LO_W         = 8,
  parameter int HI_W         = 9,
  parameter int DATA_W       = 16,
  parameter int SECS_PER_DAY = 86400,
  localparam int SEC_W       = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_day,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DAY_W-1:0]  day_q,
  output logic [SEC_W-1:0]  sec_q
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(SECS_PER_DAY - 1);

  logic any_wr;
  assign any_wr = wr_day | wr_lo | wr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      day_q <= '0;
      sec_q <= '0;
    end else if (any_wr) begin
      if (wr_day) day_q <= wdata[DAY_W-1:0];
      if (wr_lo)  sec_q[LO_W-1:0] <= wdata[LO_W-1:0];
      if (wr_hi)  sec_q[SEC_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (tick) begin
      if (sec_q >= LAST) begin
        sec_q <= '0;
        day_q <= day_q + DAY_W'(1);
      end else begin
        sec_q <= sec_q + SEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_daysec_alarm.sv
module rtc_daysec_alarm #(
  parameter int DAY_W  = 15,
  parameter int LO_W   = 8,
  parameter int HI_W   = 9,
  parameter int DATA_W = 16,
  localparam int SEC_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_day,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DAY_W-1:0]  day,
  input  logic [SEC_W-1:0]  sec,
  output logic [DAY_W-1:0]  alm_day_q,
  output logic [SEC_W-1:0]  alm_sec_q,
  output logic              hit
);
  logic match, match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_day_q <= '0;
      alm_sec_q <= '0;
    end else begin
      if (wr_day) alm_day_q <= wdata[DAY_W-1:0];
      if (wr_lo)  alm_sec_q[LO_W-1:0] <= wdata[LO_W-1:0];
      if (wr_hi)  alm_sec_q[SEC_W-1:LO_W] <= wdata[HI_W-1:0];
    end
  end

  assign match = (day == alm_day_q) && (sec == alm_sec_q);

  // After reset both sides are zero; start "already matched" so no event fires.
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b1;
    else     match_q <= match;
  end

  assign hit = match & ~match_q;
endmodule

// File: rtl/rtc_daysec_irq.sv
module rtc_daysec_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         wr_en_reg,
  input  logic         wr_stat_reg,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] en_q,
  output logic [N-1:0] stat_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_reg) en_q <= wbits;
      stat_q <= (stat_q & ~(wr_stat_reg ? wbits : '0)) | set;
      irq_q  <= |(stat_q & en_q);
    end
  end
endmodule

// File: rtl/rtc_daysec.sv
module rtc_daysec
  import rtc_daysec_pkg::*;
#(
  parameter int DAY_W        = 15,
  parameter int LO_W         = 8,
  parameter int HI_W         = 9,
  parameter int DATA_W       = 16,
  parameter int SECS_PER_DAY = 86400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  localparam int SEC_W = LO_W + HI_W;

  logic [DAY_W-1:0] day_q, alm_day_q;
  logic [SEC_W-1:0] sec_q, alm_sec_q;
  logic [IRQ_N-1:0] en_q, stat_q, irq_set;
  logic             alm_hit;
  logic [DATA_W-1:0] rd_mux;

  logic [7:0] wsel;
  always_comb begin
    wsel = '0;
    if (wr_en) wsel[addr] = 1'b1;
  end

  rtc_daysec_counter #(
    .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W), .SECS_PER_DAY(SECS_PER_DAY)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i),
    .wr_day(wsel[A_DAY]), .wr_lo(wsel[A_SEC_LO]), .wr_hi(wsel[A_SEC_HI]),
    .wdata(wdata), .day_q(day_q), .sec_q(sec_q)
  );

  rtc_daysec_alarm #(
    .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)
  ) u_alm (
    .clk(clk), .rst(rst),
    .wr_day(wsel[A_ALM_DAY]), .wr_lo(wsel[A_ALM_LO]), .wr_hi(wsel[A_ALM_HI]),
    .wdata(wdata), .day(day_q), .sec(sec_q),
    .alm_day_q(alm_day_q), .alm_sec_q(alm_sec_q), .hit(alm_hit)
  );

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_ALARM] = alm_hit;
    irq_set[IRQ_TICK]  = tick_i;
  end

  rtc_daysec_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .set(irq_set),
    .wr_en_reg(wsel[A_IRQ_EN]), .wr_stat_reg(wsel[A_IRQ_STAT]),
    .wbits(wdata[IRQ_N-1:0]),
    .en_q(en_q), .stat_q(stat_q), .irq_q(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_DAY:      rd_mux[DAY_W-1:0] = day_q;
      A_SEC_LO:   rd_mux[LO_W-1:0]  = sec_q[LO_W-1:0];
      A_SEC_HI:   rd_mux[HI_W-1:0]  = sec_q[SEC_W-1:LO_W];
      A_ALM_DAY:  rd_mux[DAY_W-1:0] = alm_day_q;
      A_ALM_LO:   rd_mux[LO_W-1:0]  = alm_sec_q[LO_W-1:0];
      A_ALM_HI:   rd_mux[HI_W-1:0]  = alm_sec_q[SEC_W-1:LO_W];
      A_IRQ_EN:   rd_mux[IRQ_N-1:0] = en_q;
      A_IRQ_STAT: rd_mux[IRQ_N-1:0] = stat_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_daysec_chk.sv
module rtc_daysec_chk #(
  parameter int DAY_W        = 15,
  parameter int LO_W         = 8,
  parameter int HI_W         = 9,
  parameter int DATA_W       = 16,
  parameter int SECS_PER_DAY = 86400,
  localparam int SEC_W       = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic [DAY_W-1:0]  day,
  input logic [SEC_W-1:0]  sec,
  input logic [1:0]        en,
  input logic [1:0]        stat
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(SECS_PER_DAY - 1);
  logic time_wr;
  assign time_wr = wr_en && (addr <= 3'd2);

  assert_count_up_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !time_wr && sec < LAST) |=> (sec == $past(sec) + SEC_W'(1) && day == $past(day)));

  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !time_wr && sec >= LAST) |=> (sec == '0 && day == $past(day) + DAY_W'(1)));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1 && tick_i) |=> (sec[LO_W-1:0] == $past(wdata[LO_W-1:0])));

  assert_tick_status_R6: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> stat[1]);

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(stat & en))));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (en == 2'b00 && stat == 2'b00 && !irq_o && day == '0 && sec == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind rtc_daysec rtc_daysec_chk #(
  .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W), .SECS_PER_DAY(SECS_PER_DAY)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
  .day(day_q), .sec(sec_q), .en(en_q), .stat(stat_q)
);

// File: tb/rtc_daysec_tb.sv
module rtc_daysec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  // reference model state
  int unsigned m_day, m_sec, m_aday, m_asec, m_en;

  always #2 clk = ~clk;

  rtc_daysec u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(string req, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model_apply(bit tk, bit we, int unsigned a, int unsigned d);
    bit twr = we && a <= 2;
    if (we) begin
      case (a)
        0: m_day  = d & 16'h7FFF;
        1: m_sec  = (m_sec & 32'h1FF00) | (d & 8'hFF);
        2: m_sec  = (m_sec & 32'hFF) | ((d & 9'h1FF) << 8);
        3: m_aday = d & 16'h7FFF;
        4: m_asec = (m_asec & 32'h1FF00) | (d & 8'hFF);
        5: m_asec = (m_asec & 32'hFF) | ((d & 9'h1FF) << 8);
        6: m_en   = d & 3;
        default: ;
      endcase
    end
    if (tk && !twr) begin
      if (m_sec >= 86399) begin
        m_sec = 0;
        m_day = (m_day + 1) & 16'h7FFF;
      end else m_sec = m_sec + 1;
    end
  endfunction

  function automatic int unsigned model_read(int unsigned a);
    case (a)
      0: return m_day;
      1: return m_sec & 8'hFF;
      2: return m_sec >> 8;
      3: return m_aday;
      4: return m_asec & 8'hFF;
      5: return m_asec >> 8;
      6: return m_en;
      default: return 0;
    endcase
  endfunction

  task automatic step(bit tk, bit we, int unsigned a, int unsigned d);
    @(negedge clk);
    tick_i = tk; wr_en = we; addr = a[2:0]; wdata = d[15:0];
    @(negedge clk);
    tick_i = 0; wr_en = 0;
    model_apply(tk, we, a, d);
  endtask

  task automatic wr(int unsigned a, int unsigned d);
    step(0, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic rd(int unsigned a, output int unsigned v);
    @(negedge clk);
    rd_en = 1; addr = a[2:0];
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unsigned v, hi0;
    void'($urandom(32'd20240611));
    m_day = 0; m_sec = 0; m_aday = 0; m_asec = 0; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R10: reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R10 reset reg", v, 0);
    end
    check("R10 irq after reset", irq_o, 0);

    // R3 / R4: field widths, upper bits zero
    wr(0, 16'hFFFF); rd(0, v); check("R3 day width", v, 16'h7FFF);
    wr(2, 16'hFFFF); rd(2, v); check("R3 sec hi width", v, 16'h01FF);
    wr(1, 16'hABCD); rd(1, v); check("R3 sec lo width", v, 16'h00CD);
    wr(3, 16'hFFFF); rd(3, v); check("R4 alarm day width", v, 16'h7FFF);
    wr(5, 16'hFE12); rd(5, v); check("R4 alarm hi width", v, 16'h0012);

    // R2: end of day wrap with day 5, then day wrap at 32767
    wr(0, 5); wr(2, 16'h151); wr(1, 16'h7F);
    step(1, 0, 0, 0);
    rd(1, v); check("R2 lo after wrap", v, 0);
    rd(2, v); check("R2 hi after wrap", v, 0);
    rd(0, v); check("R2 day incremented", v, 6);
    wr(0, 16'h7FFF); wr(2, 16'h151); wr(1, 16'h7F);
    step(1, 0, 0, 0);
    rd(0, v); check("R2 day wraps to zero", v, 0);

    // R1: plain increment
    wr(2, 3); wr(1, 16'hFE);
    step(1, 0, 0, 0); rd(1, v); check("R1 lo incremented", v, 16'hFF);
    step(1, 0, 0, 0); rd(1, v); check("R1 lo carry", v, 0);
    rd(2, v); check("R1 hi carry", v, 4);

    // R7: 255-strobe window after zero low byte
    wr(2, 5); wr(1, 0);
    for (int i = 0; i < 255; i++) step(1, 0, 0, 0);
    rd(2, v); check("R7 hi held for 255 strobes", v, 5);
    step(1, 0, 0, 0);
    rd(2, v); check("R7 hi steps on 256th strobe", v, 6);

    // R8: write wins over same-cycle strobe
    wr(1, 16'h20);
    step(1, 1, 1, 16'h10);
    rd(1, v); check("R8 write beats strobe", v, 16'h10);
    rd(2, v); check("R8 hi untouched", v, 6);

    // R5 / R9: alarm arrival
    wr(3, 2); wr(4, 44); wr(5, 1);
    wr(0, 2); wr(2, 1); wr(1, 42);
    wr(6, 1); wr(7, 3); idle(2);
    rd(7, v); check("R9 status cleared", v, 0);
    step(1, 0, 0, 0); idle(3);
    rd(7, v); check("R5 no alarm before match", v & 1, 0);
    check("R9 irq low, update masked", irq_o, 0);
    step(1, 0, 0, 0); idle(3);
    rd(7, v); check("R5 alarm status set", v & 1, 1);
    check("R9 irq on alarm", irq_o, 1);
    idle(3);
    rd(7, v); check("R5 alarm status sticky", v & 1, 1);
    wr(7, 1); idle(2);
    rd(7, v); check("R9 W1C alarm", v & 1, 0);
    check("R9 irq dropped", irq_o, 0);

    // R6 / R9: update source and masking
    wr(6, 2); wr(7, 3); idle(2);
    check("R9 irq low before strobe", irq_o, 0);
    step(1, 0, 0, 0); idle(2);
    rd(7, v); check("R6 update status", v & 2, 2);
    check("R9 irq on update", irq_o, 1);
    wr(6, 0); idle(2);
    check("R9 masked irq", irq_o, 0);
    rd(7, v); check("R9 status kept while masked", v & 2, 2);

    // R11: read data holds without read
    rd(6, v); hi0 = rdata;
    wr(0, 16'h1234); idle(2);
    check("R11 rdata holds", rdata, hi0);

    // Random mix against the model: R1 R2 R3 R4 R8 R11
    wr(6, 0);
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 3);
      int unsigned a  = $urandom_range(0, 5);
      int unsigned d  = $urandom;
      if (i % 50 == 0) begin a = 1; d = 16'h7F; wr(2, 16'h151); end
      case (op)
        0: step(1, 0, 0, 0);
        1: wr(a, d);
        2: step(1, 1, a, d);
        default: begin
          a = $urandom_range(0, 6);
          rd(a, v);
          check("R1/R2/R3/R4/R8 random read", v, model_read(a));
        end
      endcase
    end
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check("R3/R4 final readback", v, model_read(a));
    end

    finish_run();
  end
endmodule